// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This bridge sits between a bus master and a single-port, 32-bit word memory. Each memory word has 32 alias word addresses in a separate alias window, one per bit. A master that writes an alias address changes exactly one bit of the underlying word. The write is done as an indivisible read, merge and write-back on the memory port. A master that reads an alias address gets the selected bit back in bit 0. Any address outside the alias window goes to memory as an ordinary full-word read or write.

The master side uses a valid/ready request and a single-cycle response strobe. Only one request is in flight at a time. Ready stays low from acceptance until the response has been given, so no other access can reach the memory between the read and the write-back of an alias write. The memory side drives enable, write enable, word address and write data. It expects read data on the cycle after a read enable.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, `reqReady` is 1, `rspValid` is 0 and `memEn` is 0.
- R2: A read outside the alias window returns the whole memory word at index `((reqAddr - REGION_BASE) >> 2) mod 2^MEM_AW`. Address bits [1:0] are ignored.
- R3: A write outside the alias window stores all 32 bits of `reqWdata` at the word index defined in R2, using a single memory write cycle.
- R4: An address is an alias when `reqAddr - ALIAS_BASE` is below `2^MEM_AW * 128`. With `off = reqAddr - ALIAS_BASE`, the target word is `off[MEM_AW+6:7]` and the bit index is `off[6:2]`.
- R5: An alias read returns the addressed bit in `rspRdata[0]`, with bits [31:1] zero.
- R6: On an alias write only `reqWdata[0]` is used as the new bit value. Bits [31:1] of the write data have no effect.
- R7: An alias write changes only the addressed bit of the target word. The other 31 bits keep the values they had when the word was read.
- R8: `reqReady` is 1 only while the bridge is idle. An alias write drives a memory read of the target word and then, on the very next cycle, a memory write to the same word. Nothing else reaches the memory port in between.
- R9: The response comes as a one-cycle `rspValid` pulse. It follows acceptance by 2 cycles for reads and pass-through writes, and by 3 cycles for alias writes. `rspRdata` is 0 on write responses. `reqReady` returns to 1 on the cycle after the pulse.
- R10: Reset drops any request in flight. An alias write that is interrupted before its write-back leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Master request valid |
| reqReady | output | 1 | Bridge can accept a request |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data (bit 0 only, for alias writes) |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | DATA_W | Read result, valid with rspValid |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | MEM_AW | Memory word index |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, one cycle after a read enable |

## Verification
The bench targets bit positions 0 and 31 and the last word of the region. A design that decoded the word or bit fields off by one position would read or change the wrong bit, or wrap onto another word. Alias writes carry junk in the upper write-data bits. A bridge that used the whole data word, or wrote the full data word back, would corrupt the neighbouring bits. A request is held valid while the bridge is busy, and reset is applied between the read and the write-back of an alias write. These two cases expose a bridge that lets a second access in mid-sequence, or one that finishes a dropped write after reset. Every cycle the bench checks ready, the response strobe and the response latency, so a bridge with a missing or extra state would fail at once.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY_WRITE,
    ST_RESP
  } bb_state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch the accepted request
    logic memEn;     // memory access this cycle
    logic memWe;     // the access is a write
    logic rspValid;  // response cycle
  } bb_strobe_t;

endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic                       isAlias,
  output logic [MEM_AW-1:0]          wordIdx,
  output logic [$clog2(DATA_W)-1:0]  bitIdx
);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int LANE_SH   = $clog2(DATA_W / 8);
  localparam int ALIAS_SH  = BIT_W + LANE_SH;
  localparam int SPAN_BITS = MEM_AW + ALIAS_SH;

  logic [ADDR_W-1:0] aliasOff;
  logic [ADDR_W-1:0] regionOff;

  assign aliasOff  = addr - ALIAS_BASE;
  assign regionOff = addr - REGION_BASE;

  // window test: offset below the alias span
  assign isAlias = (aliasOff[ADDR_W-1:SPAN_BITS] == '0);

  always_comb begin
    if (isAlias) begin
      wordIdx = aliasOff[SPAN_BITS-1:ALIAS_SH];
    end else begin
      wordIdx = regionOff[MEM_AW+LANE_SH-1:LANE_SH];
    end
  end

  assign bitIdx = aliasOff[ALIAS_SH-1:LANE_SH];

  logic unusedBits;
  assign unusedBits = ^{aliasOff[LANE_SH-1:0], regionOff[ADDR_W-1:MEM_AW+LANE_SH],
                        regionOff[LANE_SH-1:0]};

endmodule

// File: rtl/bb_control.sv
module bb_control
  import bb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqIsAlias,
  input  logic       pendWrite,
  output logic       reqReady,
  output bb_strobe_t strobe
);
  bb_state_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          // a plain write needs no read first
          stateD = (reqWrite && !reqIsAlias) ? ST_MODIFY_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        strobe.memEn = 1'b1;
        stateD = pendWrite ? ST_MODIFY_WRITE : ST_RESP;
      end
      ST_MODIFY_WRITE: begin
        strobe.memEn = 1'b1;
        strobe.memWe = 1'b1;
        stateD = ST_RESP;
      end
      ST_RESP: begin
        strobe.rspValid = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady = (stateQ == ST_IDLE);

endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  bb_strobe_t         strobe,
  input  logic               inAlias,
  input  logic               inWrite,
  input  logic [MEM_AW-1:0]  inWord,
  input  logic [BIT_W-1:0]   inBit,
  input  logic [DATA_W-1:0]  inWdata,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               pendWrite,
  output logic [MEM_AW-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [DATA_W-1:0]  rspRdata
);
  logic               aliasQ;
  logic               writeQ;
  logic [MEM_AW-1:0]  wordQ;
  logic [BIT_W-1:0]   bitQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [DATA_W-1:0]  mergedWord;
  logic [DATA_W-1:0]  bitSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aliasQ <= 1'b0;
      writeQ <= 1'b0;
      wordQ  <= '0;
      bitQ   <= '0;
      wdataQ <= '0;
    end else if (strobe.capture) begin
      aliasQ <= inAlias;
      writeQ <= inWrite;
      wordQ  <= inWord;
      bitQ   <= inBit;
      wdataQ <= inWdata;
    end
  end

  // per-bit merge and select
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign bitSel[i]     = (bitQ == BIT_W'(i));
    assign mergedWord[i] = bitSel[i] ? wdataQ[0] : memRdata[i];
  end

  assign pendWrite = writeQ;
  assign memAddr   = wordQ;
  assign memWdata  = aliasQ ? mergedWord : wdataQ;

  always_comb begin
    rspRdata = '0;
    if (strobe.rspValid && !writeQ) begin
      if (aliasQ) begin
        rspRdata[0] = |(memRdata & bitSel);
      end else begin
        rspRdata = memRdata;
      end
    end
  end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int BIT_W = $clog2(DATA_W);

  bb_strobe_t        strobe;
  logic              decAlias;
  logic [MEM_AW-1:0] decWord;
  logic [BIT_W-1:0]  decBit;
  logic              pendWrite;

  bb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
    .ALIAS_BASE(ALIAS_BASE), .REGION_BASE(REGION_BASE)
  ) u_decode (
    .addr(reqAddr), .isAlias(decAlias), .wordIdx(decWord), .bitIdx(decBit)
  );

  bb_control u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIsAlias(decAlias), .pendWrite(pendWrite), .reqReady(reqReady),
    .strobe(strobe)
  );

  bb_datapath #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAlias(decAlias),
    .inWrite(reqWrite), .inWord(decWord), .inBit(decBit), .inWdata(reqWdata),
    .memRdata(memRdata), .pendWrite(pendWrite), .memAddr(memAddr),
    .memWdata(memWdata), .rspRdata(rspRdata)
  );

  assign memEn    = strobe.memEn;
  assign memWe    = strobe.memWe;
  assign rspValid = strobe.rspValid;

endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspRdata,
  input logic              memEn,
  input logic              memWe,
  input logic [MEM_AW-1:0] memAddr
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << (MEM_AW + $clog2(DATA_W) + 2);

  logic aliasRdPend;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aliasRdPend <= 1'b0;
    end else if (reqValid && reqReady) begin
      aliasRdPend <= !reqWrite && ((reqAddr - ALIAS_BASE) < SPAN);
    end else if (rspValid) begin
      aliasRdPend <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (reqReady && !rspValid && !memEn)); // R1

  AST_RESET_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!memWe && !rspValid)); // R10

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> !reqReady); // R8

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !rspValid)); // R8

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memEn && !memWe) && memEn && memWe) |-> (memAddr == $past(memAddr))); // R7

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady)); // R9

  AST_ALIAS_READ_ONEBIT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && aliasRdPend) |-> (rspRdata[DATA_W-1:1] == '0)); // R5

endmodule

bind bitband_bridge bb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .ALIAS_BASE(ALIAS_BASE)
) u_bb_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqWrite(reqWrite), .rspValid(rspValid),
  .rspRdata(rspRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  localparam int CLK_P = 10;
  localparam int NW = 256;
  localparam logic [31:0] ALIAS_B = 32'h2200_0000;
  localparam logic [31:0] REG_B   = 32'h2000_0000;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic reqReady;
  logic [31:0] reqAddr = 0;
  logic reqWrite = 0;
  logic [31:0] reqWdata = 0;
  logic rspValid;
  logic [31:0] rspRdata;
  logic memEn, memWe;
  logic [7:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = 0;

  logic [31:0] ram [0:NW-1];
  logic [31:0] shadow [0:NW-1];

  int nChk = 0;
  int nErr = 0;
  int cycles = 0;

  // model state
  int mLeft = 0;
  bit pWrite = 0;
  int pWord = 0;
  logic [31:0] pNew = 0;
  logic [31:0] pExp = 0;
  string pTag = "";
  bit pAliasWr = 0;

  bitband_bridge i_bitband_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[memAddr] <= memWdata;
      else memRdata <= ram[memAddr];
    end
  end

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] aAddr(int w, int b);
    return ALIAS_B + 32'(w) * 128 + 32'(b) * 4;
  endfunction

  function automatic logic [31:0] pAddr(int w);
    return REG_B + 32'(w) * 4;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  // behavioural reference, updated at each edge, compared a quarter period later
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChk++; nErr++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
    if (!rstN) begin
      mLeft = 0; pWrite = 0;
    end else if (mLeft == 0) begin
      if (reqValid) begin
        logic [31:0] off;
        bit isA;
        int b;
        off = reqAddr - ALIAS_B;
        isA = off < 32'(NW * 128);
        b = int'(off[6:2]);
        pWord = isA ? int'(off[14:7]) : int'(((reqAddr - REG_B) >> 2) & 32'hFF);
        pWrite = reqWrite;
        pAliasWr = isA && reqWrite;
        if (reqWrite) begin
          pExp = 0; pTag = "R9";
          if (isA) begin
            pNew = shadow[pWord];
            pNew[b] = reqWdata[0];
          end else pNew = reqWdata;
        end else begin
          pExp = isA ? ((shadow[pWord] >> b) & 32'h1) : shadow[pWord];
          pTag = isA ? "R5" : "R2";
        end
        mLeft = pAliasWr ? 3 : 2;
      end
    end else begin
      if (mLeft == 2 && pWrite) shadow[pWord] = pNew;
      mLeft--;
    end
    #(CLK_P/4);
    if (!rstN) begin
      chk("R10 memEn in reset", 32'(memEn), 0);
    end else begin
      chk("R8 ready", 32'(reqReady), 32'(mLeft == 0));
      chk("R9 rspValid", 32'(rspValid), 32'(mLeft == 1));
      if (mLeft == 1) chk(pTag, rspRdata, pExp);
      if (mLeft == 3 && pAliasWr) begin
        chk("R8 rmw read", {memWe, memEn}, 2'b01);
        chk("R4 read word", 32'(memAddr), 32'(pWord));
      end
      if (mLeft == 2 && pWrite) begin
        chk("R8 write strobe", {memWe, memEn}, 2'b11);
        chk(pAliasWr ? "R4 write word" : "R3 write word", 32'(memAddr), 32'(pWord));
        chk(pAliasWr ? "R7 merged word" : "R3 write data", memWdata, pNew);
      end
    end
  end

  task automatic req(logic [31:0] a, logic w, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = w; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    rd = rspRdata;
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] saved;
    logic [31:0] lcg;
    for (int i = 0; i < NW; i++) begin
      ram[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
      shadow[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(reqReady), 1);
    rstN = 1;
    @(negedge clk);
    chk("R1 ready", 32'(reqReady), 1);
    chk("R1 rspValid", 32'(rspValid), 0);
    chk("R1 memEn", 32'(memEn), 0);

    // R2 plain reads, including the last word and ignored low address bits
    req(pAddr(0), 0, 0, rd);
    req(pAddr(1) + 3, 0, 0, rd);
    req(pAddr(NW-1), 0, 0, rd);
    // R3 plain writes
    req(pAddr(3), 1, 32'hDEAD_BEEF, rd);
    req(pAddr(200), 1, 32'h0, rd);
    req(pAddr(3), 0, 0, rd);
    chk("R3 readback", rd, 32'hDEAD_BEEF);

    // R4 R5 alias reads over all bits of one word
    for (int b = 0; b < 32; b++) req(aAddr(10, b), 0, 0, rd);
    req(aAddr(3, 0), 0, 0, rd);
    chk("R5 bit0", rd, 32'h1);
    req(aAddr(3, 31), 0, 0, rd);
    chk("R5 bit31", rd, 32'h1);
    req(aAddr(3, 4), 0, 0, rd);
    chk("R5 bit4", rd, 32'h0);

    // R6 R7 alias writes
    req(aAddr(3, 4), 1, 32'h1, rd);
    req(aAddr(3, 31), 1, 32'hFFFF_FFFE, rd);
    req(aAddr(3, 0), 1, 32'h0000_0002, rd);
    req(pAddr(3), 0, 0, rd);
    chk("R6 R7 word after alias writes", rd, 32'h5EAD_BEFE);
    req(aAddr(NW-1, 31), 1, ~shadow[NW-1] >> 31, rd);
    req(aAddr(NW-1, 31), 0, 0, rd);
    req(aAddr(0, 0), 1, 32'hFFFF_FFFF, rd);

    // R8 request held valid while busy: two back to back
    @(negedge clk);
    reqValid = 1; reqAddr = aAddr(7, 13); reqWrite = 1; reqWdata = 32'h1;
    @(posedge clk);
    @(negedge clk);
    reqAddr = aAddr(7, 13); reqWrite = 0;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    chk("R8 held read sees prior write", rspRdata, 32'h1);

    // mixed traffic
    lcg = 32'h1234_5678;
    for (int k = 0; k < 80; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31]) req(aAddr(int'(lcg[15:8]), int'(lcg[20:16])), lcg[30], lcg, rd);
      else req(pAddr(int'(lcg[15:8])), lcg[30], lcg ^ 32'hA5A5_A5A5, rd);
    end

    // R10 reset between read and write-back of an alias write
    saved = shadow[20];
    @(negedge clk);
    reqValid = 1; reqAddr = aAddr(20, 3); reqWrite = 1; reqWdata = 32'(~saved[3]);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R10 ready after reset", 32'(reqReady), 1);
    req(pAddr(20), 0, 0, rd);
    chk("R10 word untouched", rd, saved);

    repeat (3) @(negedge clk);
    for (int i = 0; i < NW; i++) chk("R7 final memory", ram[i], shadow[i]);
    summary();
    $finish;
  end
endmodule